// File: doc/BRIEF.md
# Controller-to-Host Byte Output Channel

This block sits on the interface side of a link between a display controller and a host CPU, and carries bytes from the controller to the host. The controller starts a transfer by pulling its active-low load-enable low and driving a byte onto the bus. The block samples that enable only at clock edges, so decoder glitches between edges do no harm. It captures the byte on the first clock edge of each low window and raises a buffer-full flag that the host polls.

In single-byte flow-control mode, a set-ready line follows the load-enable directly. The controller therefore sees at once that this byte is the only one the interface will hold.

When the host reads the data port, it gets the held byte on that cycle and the full flag clears. An acknowledge strobe then goes low for a fixed number of cycles and returns high. That rising edge frees the controller for its next byte. If a second byte arrives before the host has read the first, the new byte replaces it and a sticky overrun flag records the loss.

Top module: `byte_out_channel`

## Requirements
- R1: After reset, `host_full` and `host_overrun` are 0 and `out_strobe` is 1.
- R2: With `SINGLE_BYTE`=1, `set_rdy` is 1 in exactly those cycles where `ld_en_n` is 0, with no clock delay.
- R3: On a clock edge where `ld_en_n` is 0 and was 1 at the previous edge, the byte on `bus_in` is captured and `host_full` is 1 after that edge.
- R4: While `ld_en_n` stays 0 over several edges, only the first of those edges captures; later bus values are ignored.
- R5: While `host_rd` is 1, `host_data` shows the held byte in the same cycle. A read while full with no new capture at that edge clears `host_full` after the edge.
- R6: While `host_rd` is 0, `host_data` is all zeros.
- R7: A read while full drives `out_strobe` low after that edge for `LOW_CYCLES` cycles, after which it returns to 1. A further read while full during the low phase restarts the count.
- R8: A read while `host_full` is 0 leaves `out_strobe` at 1 and `host_full` at 0.
- R9: A capture while full with no read at that edge replaces the held byte and sets `host_overrun`.
- R10: A capture and a read at the same edge return the old byte, leave `host_full` at 1, do not set `host_overrun`, and still pulse the strobe.
- R11: Once set, `host_overrun` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en_n | input | 1 | Controller load-enable, active low, may glitch between edges |
| bus_in | input | DATA_W | Controller data bus |
| set_rdy | output | 1 | Set-ready handshake toward the controller |
| out_strobe | output | 1 | Acknowledge strobe; its rising edge frees the controller |
| host_rd | input | 1 | Host read of the data port, one cycle per read |
| host_data | output | DATA_W | Held byte while `host_rd` is 1, else zero |
| host_full | output | 1 | Status bit: a controller byte is waiting |
| host_overrun | output | 1 | Sticky status bit: a waiting byte was overwritten |

## Verification
A wrong full flag shows up on `host_full` one edge after the load or read that should have changed it. It also shows up as a strobe pulse that is missing or unexpected on the next cycle. A wrong window-edge tracker shows up as a byte captured twice during a long low window, which a later read exposes through `host_data` or a false overrun. A wrong strobe counter changes the length of the low phase, which can be seen within `LOW_CYCLES`+1 cycles of the read. The bench runs a cycle model next to the design and compares every output in every cycle, so any such error is reported in the cycle where it first appears.

// File: rtl/boc_pkg.sv
package boc_pkg;

    typedef enum logic {
        STB_REST = 1'b0,
        STB_LOW  = 1'b1
    } stb_state_e;

    typedef struct packed {
        logic full;
        logic overrun;
    } chan_flags_t;

    // A load window opens on the edge where the enable is first seen low.
    function automatic logic window_opens(input logic prev_n, input logic cur_n);
        return prev_n & ~cur_n;
    endfunction

    // Overrun: a fresh byte lands on an unread one that is not being read now.
    function automatic logic loses_byte(input logic load, input logic full, input logic rd);
        return load & full & ~rd;
    endfunction

endpackage

// File: rtl/boc_load_detect.sv
module boc_load_detect
    import boc_pkg::*;
#(
    parameter bit SINGLE_BYTE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ld_en_n,
    output logic load,
    output logic set_rdy
);

    logic prev_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n <= 1'b1;
        end else begin
            prev_n <= ld_en_n;
        end
    end

    assign load = window_opens(prev_n, ld_en_n);

    generate
        if (SINGLE_BYTE) begin : g_single
            assign set_rdy = ~ld_en_n;
        end else begin : g_stream
            assign set_rdy = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/boc_capture.sv
module boc_capture
    import boc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              host_rd,
    output logic [DATA_W-1:0] data_q,
    output chan_flags_t       flags
);

    chan_flags_t flags_d;

    always_comb begin
        flags_d = flags;
        if (load) begin
            flags_d.full = 1'b1;
            if (loses_byte(load, flags.full, host_rd)) begin
                flags_d.overrun = 1'b1;
            end
        end else if (host_rd) begin
            flags_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            data_q <= '0;
        end else begin
            flags <= flags_d;
            if (load) begin
                data_q <= bus_in;
            end
        end
    end

endmodule

// File: rtl/boc_strobe.sv
module boc_strobe
    import boc_pkg::*;
#(
    parameter int LOW_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic strobe
);

    localparam int CW = $clog2(LOW_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOW_CYCLES - 1);

    stb_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= STB_REST;
            cnt   <= '0;
        end else if (ack) begin
            state <= STB_LOW;
            cnt   <= LAST;
        end else if (state == STB_LOW) begin
            if (cnt == '0) begin
                state <= STB_REST;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign strobe = (state == STB_REST);

endmodule

// File: rtl/byte_out_channel.sv
module byte_out_channel
    import boc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LOW_CYCLES  = 2,
    parameter bit SINGLE_BYTE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic              set_rdy,
    output logic              out_strobe,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_data,
    output logic              host_full,
    output logic              host_overrun
);

    logic              load;
    logic [DATA_W-1:0] data_q;
    chan_flags_t       flags;
    logic              ack;

    boc_load_detect #(.SINGLE_BYTE(SINGLE_BYTE)) u_det (
        .clk     (clk),
        .rst     (rst),
        .ld_en_n (ld_en_n),
        .load    (load),
        .set_rdy (set_rdy)
    );

    boc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .bus_in  (bus_in),
        .host_rd (host_rd),
        .data_q  (data_q),
        .flags   (flags)
    );

    assign ack = host_rd & flags.full;

    boc_strobe #(.LOW_CYCLES(LOW_CYCLES)) u_stb (
        .clk    (clk),
        .rst    (rst),
        .ack    (ack),
        .strobe (out_strobe)
    );

    assign host_data    = host_rd ? data_q : '0;
    assign host_full    = flags.full;
    assign host_overrun = flags.overrun;

endmodule

// File: rtl/boc_checker.sv
module boc_checker #(
    parameter int DATA_W      = 8,
    parameter bit SINGLE_BYTE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_en_n,
    input logic              set_rdy,
    input logic              out_strobe,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_data,
    input logic              host_full,
    input logic              host_overrun
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!host_full && !host_overrun && out_strobe));

    a_r2_set_ready: assert property (@(posedge clk) disable iff (rst)
        SINGLE_BYTE |-> (set_rdy == !ld_en_n));

    a_r3_full_after_load: assert property (@(posedge clk) disable iff (rst)
        (!ld_en_n && !$past(ld_en_n) == 1'b0 && $past(rst) == 1'b0) |=> host_full);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_full && ld_en_n) |=> !host_full);

    a_r6_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !host_rd |-> (host_data == '0));

    a_r7_strobe_low: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_full) |=> !out_strobe);

    a_r8_no_pulse_empty: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_full && out_strobe) |=> out_strobe);

    a_r11_sticky_overrun: assert property (@(posedge clk) disable iff (rst)
        host_overrun |=> host_overrun);

endmodule

bind byte_out_channel boc_checker #(
    .DATA_W      (DATA_W),
    .SINGLE_BYTE (SINGLE_BYTE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ld_en_n      (ld_en_n),
    .set_rdy      (set_rdy),
    .out_strobe   (out_strobe),
    .host_rd      (host_rd),
    .host_data    (host_data),
    .host_full    (host_full),
    .host_overrun (host_overrun)
);

// File: tb/sim_byte_out_channel.sv
module sim_byte_out_channel;

    localparam int DW  = 8;
    localparam int LOW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en_n = 1'b1;
    logic [DW-1:0] bus_in = '0;
    logic          host_rd = 1'b0;
    logic          set_rdy, out_strobe, host_full, host_overrun;
    logic [DW-1:0] host_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // cycle model state
    logic          m_prev = 1'b1;
    logic          m_full = 1'b0;
    logic          m_ovr = 1'b0;
    logic [DW-1:0] m_data = '0;
    int            m_cnt = 0;

    always #2 clk = ~clk;

    byte_out_channel u0 (
        .clk(clk), .rst(rst), .ld_en_n(ld_en_n), .bus_in(bus_in),
        .set_rdy(set_rdy), .out_strobe(out_strobe), .host_rd(host_rd),
        .host_data(host_data), .host_full(host_full), .host_overrun(host_overrun)
    );

    function automatic logic [DW-1:0] exp_data(input logic rd, input logic [DW-1:0] held);
        return rd ? held : '0;
    endfunction

    function automatic logic exp_ovr(input logic ovr, input logic load, input logic full, input logic rd);
        return ovr | (load & full & ~rd);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_prev = 1'b1; m_full = 1'b0; m_ovr = 1'b0; m_data = '0; m_cnt = 0;
    endtask

    // drive one cycle, compare every output, advance the model past the edge
    task automatic step(input logic ld, input logic [DW-1:0] b, input logic rd);
        logic load;
        logic rd_ok;
        @(negedge clk);
        ld_en_n = ld; bus_in = b; host_rd = rd;
        #1;
        check("R2 set_rdy", set_rdy, !ld);
        check("R5/R6 host_data", host_data, exp_data(rd, m_data));
        check("R3/R5 host_full", host_full, m_full);
        check("R9/R11 host_overrun", host_overrun, m_ovr);
        check("R7/R8 out_strobe", out_strobe, m_cnt == 0);
        load  = m_prev & ~ld;
        rd_ok = rd & m_full;
        m_ovr = exp_ovr(m_ovr, load, m_full, rd);
        if (load) begin
            m_data = b;
            m_full = 1'b1;
        end else if (rd) begin
            m_full = 1'b0;
        end
        if (rd_ok) m_cnt = LOW;
        else if (m_cnt > 0) m_cnt--;
        m_prev = ld;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ld_en_n = 1'b1; host_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check("R1 full", host_full, 1'b0);
        check("R1 overrun", host_overrun, 1'b0);
        check("R1 strobe", out_strobe, 1'b1);
    endtask

    initial begin
        process::self().srandom(32'd1207);
        do_reset();

        // R3 / R5 / R7: one byte in, one read out
        step(1'b0, 8'hA5, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        #1 check("R3 full after load", host_full, 1'b1);
        step(1'b1, 8'h00, 1'b1);
        step(1'b1, 8'h00, 1'b0);
        #1 check("R7 strobe low after read", out_strobe, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        #1 check("R7 strobe back high", out_strobe, 1'b1);

        // R4: long low window, bus changes ignored
        step(1'b0, 8'h11, 1'b0);
        step(1'b0, 8'h22, 1'b0);
        step(1'b0, 8'h33, 1'b0);
        step(1'b1, 8'h44, 1'b0);
        @(negedge clk); host_rd = 1'b1; #1;
        check("R4 first byte kept", host_data, 8'h11);
        check("R4 no false overrun", host_overrun, 1'b0);
        m_prev = 1'b1; m_full = 1'b0; m_cnt = LOW;
        step(1'b1, 8'h00, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        step(1'b1, 8'h00, 1'b0);

        // R8: read while empty
        step(1'b1, 8'h00, 1'b1);
        #1 check("R8 strobe stays high", out_strobe, 1'b1);
        check("R8 full stays low", host_full, 1'b0);

        // R10: capture and read at one edge
        step(1'b0, 8'h5A, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        @(negedge clk); host_rd = 1'b1; ld_en_n = 1'b0; bus_in = 8'hC3; #1;
        check("R10 old byte returned", host_data, 8'h5A);
        m_data = 8'hC3; m_full = 1'b1; m_cnt = LOW; m_prev = 1'b0;
        step(1'b1, 8'h00, 1'b0);
        #1 check("R10 still full", host_full, 1'b1);
        check("R10 no overrun", host_overrun, 1'b0);
        check("R10 strobe pulsed", out_strobe, 1'b0);

        // R9 / R11: overwrite while full
        step(1'b0, 8'h77, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        #1 check("R9 overrun set", host_overrun, 1'b1);
        step(1'b1, 8'h00, 1'b1);
        step(1'b1, 8'h00, 1'b0);
        #1 check("R11 overrun sticky", host_overrun, 1'b1);

        do_reset();

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic ld;
            ld = ($urandom_range(0, 9) < 4) ? 1'b0 : 1'b1;
            step(ld, 8'($urandom), ($urandom_range(0, 9) < 3));
            if (i == 2000) do_reset();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule